// File: doc/BRIEF.md
# Message-Signalled Interrupt Termination Bank

This block is the landing zone for message-signalled interrupt writes arriving from an I/O fabric. Each incoming message carries a target address and a small data word. The address picks one of 128 pending registers, organised as 16 groups of 8. The data word picks one of the 16 vector bits inside that register, and the block sets that bit. Software reads a per-group summary to learn which of the eight registers in a group hold pending vectors. It then reads those registers, and each read returns the pending bits and clears them.

Each group has one level interrupt output toward the host interrupt controller. The output stays high while any register in that group holds a pending bit. The register read port is separate from the message write port, so a message can arrive in the same cycle as a clearing read. In that case the new message is never lost.

Top module: `msi_term_bank`

## Requirements
- R1: A write with `wr_en` high, address `(n << 19) + (x << 16)` (n in 0..15, x in 0..7) and data d in 0..15 sets bit d of pending register x in group n. A later read of that same address returns the bit.
- R2: A read of a pending-register address returns its value in `rd_data` in the cycle after `rd_en`, and clears the register in the same access, so an immediate second read returns 0. `rd_data` holds its value until the next read.
- R3: A read at address `0x800000 + (n << 16)` returns the summary of group n. Bit x is 1 exactly when pending register x of group n is non-zero, and bits 15..8 read 0.
- R4: A summary read changes no state: repeated summary reads return the same value and leave `irq_out` unchanged.
- R5: `irq_out[n]` is high exactly when the summary of group n is non-zero. It follows each accepted write or clearing read one cycle later.
- R6: When a message write and a clearing read hit the same pending register in one cycle, the written bit is present afterwards. The read data shows that bit only if it was already set before that cycle.
- R7: A write whose address is not a pending-register address (low 16 bits non-zero, summary region, or other offsets), or whose data is 16 or more, changes no register. It also pulses `wr_err` high for exactly the cycle after the write.
- R8: Reset (`rst` high, synchronous) clears every pending register, drives `irq_out`, `rd_data` and `wr_err` to 0.
- R9: Reads of addresses that decode to neither region return 0. Writes to distinct bits of one register accumulate, and writing an already-set bit again has no further effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Message write strobe |
| wr_addr | input | 24 | Message target byte offset |
| wr_data | input | 32 | Message data (vector number) |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 24 | Register read byte offset |
| rd_data | output | 16 | Registered read data |
| wr_err | output | 1 | One-cycle strobe for a rejected write |
| irq_out | output | 16 | Per-group level interrupt |

## Verification
Every result of this block is one register stage from its stimulus. `rd_data`, the clearing effect of a read, `wr_err` and the `irq_out` change caused by a write or read all become visible after the single clock edge that samples the strobe. The bench drives strobes on the falling edge and inspects results on the next falling edge. Read results are pushed into a queue at issue and popped by a monitor one cycle later. Write-side results (`wr_err`, `irq_out`) are compared against a reference model in that same following half-period.

// File: rtl/msi_pkg.sv
package msi_pkg;
  // Region selected by a decoded byte offset
  typedef enum logic [1:0] {
    RGN_NONE = 2'd0,
    RGN_IDX  = 2'd1,
    RGN_SUM  = 2'd2
  } rgn_e;
endpackage

// File: rtl/msi_addr_dec.sv
module msi_addr_dec
  import msi_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int GRP_W   = 4,
  parameter int IDX_W   = 3,
  parameter int SLOT_SH = 16
) (
  input  logic [ADDR_W-1:0]      addr,
  output rgn_e                   rgn,
  output logic [GRP_W+IDX_W-1:0] sel
);
  localparam int IDX_TOP = SLOT_SH + IDX_W + GRP_W;
  localparam int SUM_TOP = SLOT_SH + GRP_W;
  localparam int SUM_TAG = 1 << (ADDR_W - 1 - SUM_TOP);

  logic              low_clr;
  logic [ADDR_W-1:0] above_idx;
  logic [ADDR_W-1:0] above_sum;

  always_comb begin
    low_clr   = (addr[SLOT_SH-1:0] == '0);
    above_idx = addr >> IDX_TOP;
    above_sum = addr >> SUM_TOP;
    rgn       = RGN_NONE;
    sel       = '0;
    if (low_clr && above_idx == '0) begin
      rgn = RGN_IDX;
      sel = addr[IDX_TOP-1:SLOT_SH];
    end else if (low_clr && above_sum == ADDR_W'(SUM_TAG)) begin
      rgn = RGN_SUM;
      sel = {addr[SUM_TOP-1:SLOT_SH], {IDX_W{1'b0}}};
    end
  end
endmodule

// File: rtl/msi_vec_reg.sv
module msi_vec_reg #(
  parameter int N_VEC = 16,
  parameter int VEC_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en,
  input  logic [VEC_W-1:0] set_bit,
  input  logic             clr_en,
  output logic [N_VEC-1:0] q,
  output logic             nz,
  output logic             nz_next
);
  logic [N_VEC-1:0] nxt;

  // Clear first, then set: a same-cycle message survives the read-clear
  always_comb begin
    nxt     = (clr_en ? '0 : q) | (set_en ? (N_VEC'(1) << set_bit) : '0);
    nz      = |q;
    nz_next = |nxt;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end
endmodule

// File: rtl/msi_grp_irq.sv
module msi_grp_irq #(
  parameter int N_GRP = 16,
  parameter int N_IDX = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [N_GRP*N_IDX-1:0] nz_next,
  output logic [N_GRP-1:0]       irq_q
);
  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    always_ff @(posedge clk) begin
      if (rst) irq_q[g] <= 1'b0;
      else     irq_q[g] <= |nz_next[g*N_IDX +: N_IDX];
    end
  end
endmodule

// File: rtl/msi_term_bank.sv
module msi_term_bank
  import msi_pkg::*;
#(
  parameter int N_GRP   = 16,
  parameter int N_IDX   = 8,
  parameter int N_VEC   = 16,
  parameter int ADDR_W  = 24,
  parameter int DATA_W  = 32,
  parameter int SLOT_SH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [N_VEC-1:0]  rd_data,
  output logic              wr_err,
  output logic [N_GRP-1:0]  irq_out
);
  localparam int GRP_W = $clog2(N_GRP);
  localparam int IDX_W = $clog2(N_IDX);
  localparam int VEC_W = $clog2(N_VEC);
  localparam int SEL_W = GRP_W + IDX_W;
  localparam int N_REG = N_GRP * N_IDX;

  rgn_e             wr_rgn, rd_rgn;
  logic [SEL_W-1:0] wr_sel, rd_sel;
  logic             wr_ok, rd_clr;
  logic [N_VEC-1:0] vec_q [N_REG];
  logic [N_REG-1:0] nz_cur, nz_nxt;
  logic [N_VEC-1:0] rd_nxt;
  logic [N_VEC-1:0] rd_q;
  logic             err_q;

  msi_addr_dec #(.ADDR_W(ADDR_W), .GRP_W(GRP_W), .IDX_W(IDX_W), .SLOT_SH(SLOT_SH))
    u_wdec (.addr(wr_addr), .rgn(wr_rgn), .sel(wr_sel));
  msi_addr_dec #(.ADDR_W(ADDR_W), .GRP_W(GRP_W), .IDX_W(IDX_W), .SLOT_SH(SLOT_SH))
    u_rdec (.addr(rd_addr), .rgn(rd_rgn), .sel(rd_sel));

  assign wr_ok  = wr_en && (wr_rgn == RGN_IDX) && (wr_data < DATA_W'(N_VEC));
  assign rd_clr = rd_en && (rd_rgn == RGN_IDX);

  for (genvar r = 0; r < N_REG; r++) begin : g_reg
    msi_vec_reg #(.N_VEC(N_VEC), .VEC_W(VEC_W)) u_reg (
      .clk    (clk),
      .rst    (rst),
      .set_en (wr_ok && (wr_sel == SEL_W'(r))),
      .set_bit(wr_data[VEC_W-1:0]),
      .clr_en (rd_clr && (rd_sel == SEL_W'(r))),
      .q      (vec_q[r]),
      .nz     (nz_cur[r]),
      .nz_next(nz_nxt[r])
    );
  end

  msi_grp_irq #(.N_GRP(N_GRP), .N_IDX(N_IDX)) u_irq (
    .clk    (clk),
    .rst    (rst),
    .nz_next(nz_nxt),
    .irq_q  (irq_out)
  );

  // Read mux uses pre-edge state, so a same-cycle message is not returned
  always_comb begin
    case (rd_rgn)
      RGN_IDX: rd_nxt = vec_q[rd_sel];
      RGN_SUM: rd_nxt = N_VEC'(nz_cur[rd_sel +: N_IDX]);
      default: rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q  <= '0;
      err_q <= 1'b0;
    end else begin
      err_q <= wr_en && !wr_ok;
      if (rd_en) rd_q <= rd_nxt;
    end
  end

  assign rd_data = rd_q;
  assign wr_err  = err_q;
endmodule

// File: rtl/msi_term_chk.sv
module msi_term_chk #(
  parameter int N_GRP   = 16,
  parameter int N_IDX   = 8,
  parameter int N_VEC   = 16,
  parameter int ADDR_W  = 24,
  parameter int DATA_W  = 32,
  parameter int SLOT_SH = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [N_VEC-1:0]  rd_data,
  input logic              wr_err,
  input logic [N_GRP-1:0]  irq_out
);
  localparam int GRP_W   = $clog2(N_GRP);
  localparam int IDX_W   = $clog2(N_IDX);
  localparam int SUM_TOP = SLOT_SH + GRP_W;
  localparam int SUM_TAG = 1 << (ADDR_W - 1 - SUM_TOP);

  logic             w_valid, r_is_sum;
  logic [GRP_W-1:0] w_grp;

  assign w_valid  = (wr_addr[SLOT_SH-1:0] == '0) &&
                    ((wr_addr >> (SLOT_SH + IDX_W + GRP_W)) == '0) &&
                    (wr_data < DATA_W'(N_VEC));
  assign w_grp    = wr_addr[SLOT_SH+IDX_W +: GRP_W];
  assign r_is_sum = (rd_addr[SLOT_SH-1:0] == '0) &&
                    ((rd_addr >> SUM_TOP) == ADDR_W'(SUM_TAG));

  // R5
  accepted_write_raises_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && w_valid) |=> irq_out[$past(w_grp)]);

  // R7
  bad_write_strobes_err_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !w_valid) |=> wr_err);

  // R7
  no_write_no_err_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> !wr_err);

  // R4
  summary_read_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && r_is_sum && !wr_en) |=> $stable(irq_out));

  // R5
  irq_falls_only_on_read_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> ((irq_out & $past(irq_out)) == $past(irq_out)));

  // R2
  rd_data_holds_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
endmodule

bind msi_term_bank msi_term_chk #(
  .N_GRP(N_GRP), .N_IDX(N_IDX), .N_VEC(N_VEC),
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SLOT_SH(SLOT_SH)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .wr_err(wr_err),
  .irq_out(irq_out)
);

// File: tb/sim_msi_term_bank.sv
module sim_msi_term_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [23:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [23:0] rd_addr = '0;
  logic [15:0] rd_data;
  logic        wr_err;
  logic [15:0] irq_out;

  int n_run  = 0;
  int n_fail = 0;

  logic [15:0] mdl [16][8];
  logic [15:0] exp_q [$];
  string       tag_q [$];
  logic        rd_seen = 1'b0;

  always #2 clk = ~clk;

  msi_term_bank u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .wr_err(wr_err),
    .irq_out(irq_out)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] ia(input int n, input int x);
    return 24'((n << 19) | (x << 16));
  endfunction

  function automatic logic [23:0] sa(input int n);
    return 24'(24'h800000 | (n << 16));
  endfunction

  function automatic logic [15:0] mdl_irq();
    logic [15:0] v = '0;
    for (int g = 0; g < 16; g++)
      for (int x = 0; x < 8; x++)
        if (mdl[g][x] != 0) v[g] = 1'b1;
    return v;
  endfunction

  function automatic logic [15:0] mdl_sum(input int g);
    logic [15:0] v = '0;
    for (int x = 0; x < 8; x++) v[x] = (mdl[g][x] != 0);
    return v;
  endfunction

  // Expected read value from a decoded address, applying read-clear to the model
  function automatic logic [15:0] mdl_read(input logic [23:0] a);
    logic [15:0] v = '0;
    if (a[15:0] == 0 && a[23] == 1'b0) begin
      v = mdl[a[22:19]][a[18:16]];
      mdl[a[22:19]][a[18:16]] = '0;
    end else if (a[15:0] == 0 && a[23:20] == 4'h8) begin
      v = mdl_sum(a[19:16]);
    end
    return v;
  endfunction

  // Monitor: pops the expected read result one cycle after issue
  always @(posedge clk) rd_seen <= rd_en;
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(rd_data == e, t, 32'(rd_data), 32'(e));
    end
  end

  task automatic do_read(input logic [23:0] a, input string tag);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    exp_q.push_back(mdl_read(a));
    tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
    chk(irq_out == mdl_irq(), "R5 irq after read", 32'(irq_out), 32'(mdl_irq()));
  endtask

  task automatic do_write(input logic [23:0] a, input logic [31:0] d,
                          input logic bad, input string tag);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    if (!bad) mdl[a[22:19]][a[18:16]][d[3:0]] = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    chk(wr_err == bad, {tag, " wr_err"}, 32'(wr_err), 32'(bad));
    chk(irq_out == mdl_irq(), {tag, " irq"}, 32'(irq_out), 32'(mdl_irq()));
  endtask

  // Simultaneous message write and clearing read of one register
  task automatic do_both(input int n, input int x, input int d, input string tag);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = ia(n, x); wr_data = 32'(d);
    rd_en = 1'b1; rd_addr = ia(n, x);
    exp_q.push_back(mdl_read(ia(n, x)));
    tag_q.push_back(tag);
    mdl[n][x][d] = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    chk(irq_out == mdl_irq(), "R6 irq", 32'(irq_out), 32'(mdl_irq()));
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int g = 0; g < 16; g++)
      for (int x = 0; x < 8; x++) mdl[g][x] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R8 reset state
    chk(irq_out == 0, "R8 irq", 32'(irq_out), 0);
    chk(wr_err == 0, "R8 wr_err", 32'(wr_err), 0);
    chk(rd_data == 0, "R8 rd_data", 32'(rd_data), 0);
    do_read(sa(0), "R8 summary after reset");

    // R1 R3 R5 R2
    do_write(ia(3, 5), 9, 1'b0, "R1 write g3 i5");
    do_read(sa(3), "R3 summary g3");
    do_read(ia(3, 5), "R1 readback g3 i5");
    do_read(ia(3, 5), "R2 cleared g3 i5");

    // R9 accumulation and idempotent rewrite
    do_write(ia(0, 0), 0, 1'b0, "R9 bit0");
    do_write(ia(0, 0), 15, 1'b0, "R9 bit15");
    do_write(ia(0, 0), 0, 1'b0, "R9 rewrite bit0");
    do_read(ia(0, 0), "R9 accumulated");

    // R3 R4 multiple registers, repeated summary reads
    do_write(ia(15, 7), 1, 1'b0, "R1 write g15 i7");
    do_write(ia(15, 2), 4, 1'b0, "R1 write g15 i2");
    do_read(sa(15), "R3 summary g15");
    do_read(sa(15), "R4 summary reread g15");
    do_read(ia(15, 2), "R2 read g15 i2");
    do_read(sa(15), "R3 summary g15 after clear");
    do_read(ia(15, 7), "R2 read g15 i7");

    // R6 same-cycle write and read-clear
    do_write(ia(7, 1), 3, 1'b0, "R6 preset");
    do_both(7, 1, 3, "R6 bit already set");
    do_both(7, 1, 6, "R6 new bit hidden");
    do_read(ia(7, 1), "R6 survivor");

    // R7 rejected writes
    do_write(24'h000004, 2, 1'b1, "R7 low offset bits");
    do_write(ia(2, 2), 16, 1'b1, "R7 data 16");
    do_write(sa(4), 1, 1'b1, "R7 summary region");
    do_write(24'h900000, 1, 1'b1, "R7 unmapped");
    do_read(ia(2, 2), "R7 no effect g2 i2");
    do_read(ia(0, 0), "R7 no effect g0 i0");
    do_read(sa(4), "R7 no effect summary g4");

    // R9 unmapped reads
    do_read(24'h810004, "R9 unmapped read a");
    do_read(24'h900000, "R9 unmapped read b");

    // R8 reset with pending state
    do_write(ia(9, 3), 5, 1'b0, "R1 write g9 i3");
    @(negedge clk); rst = 1'b1;
    for (int g = 0; g < 16; g++)
      for (int x = 0; x < 8; x++) mdl[g][x] = '0;
    @(negedge clk); rst = 1'b0;
    chk(irq_out == 0, "R8 irq after reset", 32'(irq_out), 0);
    do_read(ia(9, 3), "R8 register cleared");

    repeat (2) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule